// File: doc/BRIEF.md
# SDRAM Self-Refresh Sequencer

This block sits inside an SDRAM controller and takes the memory into and out of its self-refresh low-power state. When the controller raises `sleep_req` while the sequencer is idle, the block closes every open bank with an all-bank precharge. It then waits out the row precharge time and drops the clock enable in the same cycle that it issues a refresh command. From then on the device refreshes itself, and the block holds the clock enable low for as long as needed. No upper time limit applies.

A wake request raises the clock enable again. The block then keeps the command bus quiet for the exit recovery interval, which is never shorter than two clocks. After that it pulses `ready` to tell the controller that normal traffic may resume. In the same cycle it pulses `rtimer_restart` so that the controller's periodic refresh interval timer starts a fresh period. A wake request that arrives while entry is still in progress is held, and it takes effect once the device is in self-refresh, so entry always runs to completion. The data output enable stays off for the whole sequence. Every output comes straight from a flop, and the clock is assumed to be running and stable whenever `wake_req` is raised.

Top module: `sdram_sleep_seq`

## Requirements
- R1: After synchronous reset, the outputs are: `cke`=1, a NOP command ({cs_n,ras_n,cas_n,we_n}=4'b0111), `a10`=0, `ba`=0, `ready`=0 and `rtimer_restart`=0.
- R2: `sleep_req` sampled high while idle gives, in the next cycle, a PRECHARGE command (4'b0010) with `a10`=1 (all banks), `ba`=0 and `cke`=1.
- R3: The refresh command (4'b0001) follows the PRECHARGE by exactly max(RP_CYC,2) cycles. Every cycle in between carries NOP with `cke`=1.
- R4: `cke` goes low in the same cycle as the refresh command and stays low while the device is in self-refresh, with no time limit. During self-refresh the command bus carries COMMAND INHIBIT (4'b1111).
- R5: `wake_req` sampled high during self-refresh gives `cke`=1 with NOP in the next cycle.
- R6: A wake request sampled from the PRECHARGE cycle through the refresh cycle is held. Entry completes, the device spends exactly one cycle in self-refresh, and then `cke` rises.
- R7: From the cycle `cke` rises, only NOP appears on the bus. `ready` is high for exactly one cycle, exactly max(XSR_CYC,2) cycles after the rise, and the block is then idle again.
- R8: `rtimer_restart` pulses for one cycle, in the same cycle as `ready`.
- R9: `dq_oe` is 0 in every cycle.
- R10: `sleep_req` has no effect outside the idle state, and `wake_req` has no effect while idle or while the exit sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter self-refresh (acted on only when idle) |
| wake_req | input | 1 | Request to leave self-refresh |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10 (all-bank select for precharge) |
| ba | output | BA_W | Bank address |
| dq_oe | output | 1 | Data bus output enable, always low |
| ready | output | 1 | One-cycle pulse: normal traffic may resume |
| rtimer_restart | output | 1 | One-cycle pulse restarting the refresh interval timer |

## Verification
The bench drives two instances side by side. One uses RP_CYC=3 and XSR_CYC=6, and the other uses values below the two-cycle floor, so the check also shows whether that floor is applied. The patterns are:
- an isolated entry with a long self-refresh stay, which separates the entry and exit timing;
- a wake pulse in the precharge cycle, which shows whether early wakes are held or dropped;
- a `sleep_req` held high across a whole cycle, which shows whether it is ignored mid-sequence and re-entry happens straight after `ready`;
- a `wake_req` held high from idle, which catches wakes acted on in the wrong states.

A behavioural reference model predicts every output on every clock.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE_ALL,
    ST_WAIT_RP,
    ST_ENTER,
    ST_IN_SR,
    ST_EXIT,
    ST_WAIT_XSR,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP       = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_INHIBIT   = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_PRECHARGE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdr_cmd_t CMD_REFRESH   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  // Raise a cycle count to a minimum value.
  function automatic int unsigned floor_cycles(int unsigned v, int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/sleep_delay_ctr.sv
module sleep_delay_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

  // R3 / R7: the count walks down by one and never wraps.
  a_r3_ctr_steps_down: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && ($past(cnt) != '0)) |-> (cnt == $past(cnt) - 1'b1));

  a_r7_ctr_holds_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && ($past(cnt) == '0)) |-> (cnt == '0));

endmodule

// File: rtl/sleep_wake_hold.sv
module sleep_wake_hold (
  input  logic clk,
  input  logic rst,
  input  logic capture_en,
  input  logic wake_req,
  input  logic clear,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pending <= 1'b0;
    end else if (capture_en && wake_req) begin
      pending <= 1'b1;
    end
  end

  // R6: a captured wake stays held until it is cleared.
  a_r6_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
    ($past(pending) && !$past(clear)) |-> pending);

endmodule

// File: rtl/sleep_cmd_reg.sv
module sleep_cmd_reg
  import sleep_seq_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_state_t      nxt,
  output logic            cke,
  output sdr_cmd_t        cmd,
  output logic            a10,
  output logic [BA_W-1:0] ba,
  output logic            ready,
  output logic            restart
);

  logic     d_cke;
  sdr_cmd_t d_cmd;
  logic     d_a10;
  logic     d_done;

  always_comb begin
    d_cke  = 1'b1;
    d_cmd  = CMD_NOP;
    d_a10  = 1'b0;
    d_done = 1'b0;
    unique case (nxt)
      ST_PRE_ALL: begin
        d_cmd = CMD_PRECHARGE;
        d_a10 = 1'b1;
      end
      ST_ENTER: begin
        d_cke = 1'b0;
        d_cmd = CMD_REFRESH;
      end
      ST_IN_SR: begin
        d_cke = 1'b0;
        d_cmd = CMD_INHIBIT;
      end
      ST_DONE:  d_done = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cke     <= 1'b1;
      cmd     <= CMD_NOP;
      a10     <= 1'b0;
      ba      <= '0;
      ready   <= 1'b0;
      restart <= 1'b0;
    end else begin
      cke     <= d_cke;
      cmd     <= d_cmd;
      a10     <= d_a10;
      ba      <= '0;
      ready   <= d_done;
      restart <= d_done;
    end
  end

endmodule

// File: rtl/sdram_sleep_seq.sv
module sdram_sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int unsigned RP_CYC  = 3,
  parameter int unsigned XSR_CYC = 10,
  parameter int          BA_W    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sleep_req,
  input  logic            wake_req,
  output logic            cke,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            a10,
  output logic [BA_W-1:0] ba,
  output logic            dq_oe,
  output logic            ready,
  output logic            rtimer_restart
);

  localparam int unsigned RP_EFF  = floor_cycles(RP_CYC, 2);
  localparam int unsigned XSR_EFF = floor_cycles(XSR_CYC, 2);
  localparam int unsigned MAX_EFF = (RP_EFF > XSR_EFF) ? RP_EFF : XSR_EFF;
  localparam int          CW      = $clog2(MAX_EFF + 1);
  localparam logic [CW-1:0] RP_LOAD  = CW'(RP_EFF - 2);
  localparam logic [CW-1:0] XSR_LOAD = CW'(XSR_EFF - 2);

  seq_state_t state, nxt;
  logic       wait_zero;
  logic       wake_pend;
  logic       ctr_load;
  logic [CW-1:0] ctr_val;
  sdr_cmd_t   cmd;

  // One shared down-counter times both the precharge and the exit waits.
  assign ctr_load = (state == ST_PRE_ALL) || (state == ST_EXIT);
  assign ctr_val  = (state == ST_EXIT) ? XSR_LOAD : RP_LOAD;

  sleep_delay_ctr #(.W(CW)) delay_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ctr_load),
    .load_val (ctr_val),
    .zero     (wait_zero)
  );

  sleep_wake_hold wake_i (
    .clk        (clk),
    .rst        (rst),
    .capture_en ((state == ST_PRE_ALL) || (state == ST_WAIT_RP) || (state == ST_ENTER)),
    .wake_req   (wake_req),
    .clear      (state == ST_EXIT),
    .pending    (wake_pend)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (sleep_req) nxt = ST_PRE_ALL;
      ST_PRE_ALL:  nxt = ST_WAIT_RP;
      ST_WAIT_RP:  if (wait_zero) nxt = ST_ENTER;
      ST_ENTER:    nxt = ST_IN_SR;
      ST_IN_SR:    if (wake_req || wake_pend) nxt = ST_EXIT;
      ST_EXIT:     nxt = ST_WAIT_XSR;
      ST_WAIT_XSR: if (wait_zero) nxt = ST_DONE;
      ST_DONE:     nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  sleep_cmd_reg #(.BA_W(BA_W)) out_i (
    .clk     (clk),
    .rst     (rst),
    .nxt     (nxt),
    .cke     (cke),
    .cmd     (cmd),
    .a10     (a10),
    .ba      (ba),
    .ready   (ready),
    .restart (rtimer_restart)
  );

  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;
  assign dq_oe = 1'b0;

  a_r2_precharge_all_banks: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRECHARGE) |-> (a10 && cke));

  a_r3_refresh_after_quiet: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REFRESH) |-> ($past(cmd) == CMD_NOP && $past(cke)));

  a_r4_cke_falls_on_refresh: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> (cmd == CMD_REFRESH));

  a_r5_wake_raises_cke: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IN_SR && wake_req) |=> cke);

  a_r6_pending_wake_acts: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IN_SR && wake_pend) |=> (cke && cmd == CMD_NOP));

  a_r7_nop_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (cmd == CMD_NOP));

  a_r7_ready_single: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r8_restart_after_exit: assert property (@(posedge clk) disable iff (rst)
    rtimer_restart |-> ($past(cke) && $past(cmd) == CMD_NOP));

endmodule

// File: tb/sdram_sleep_seq_tb_top.sv
module sdram_sleep_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic wake_req  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic       cke_o [2];
  logic [3:0] cmd_o [2];
  logic       a10_o [2];
  logic [1:0] ba_o  [2];
  logic       oe_o  [2];
  logic       rdy_o [2];
  logic       rst_o [2];

  sdram_sleep_seq #(.RP_CYC(3), .XSR_CYC(6), .BA_W(2)) dut_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .cke(cke_o[0]), .cs_n(cmd_o[0][3]), .ras_n(cmd_o[0][2]), .cas_n(cmd_o[0][1]),
    .we_n(cmd_o[0][0]), .a10(a10_o[0]), .ba(ba_o[0]), .dq_oe(oe_o[0]),
    .ready(rdy_o[0]), .rtimer_restart(rst_o[0])
  );

  sdram_sleep_seq #(.RP_CYC(1), .XSR_CYC(0), .BA_W(2)) dut_min_i (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .cke(cke_o[1]), .cs_n(cmd_o[1][3]), .ras_n(cmd_o[1][2]), .cas_n(cmd_o[1][1]),
    .we_n(cmd_o[1][0]), .a10(a10_o[1]), .ba(ba_o[1]), .dq_oe(oe_o[1]),
    .ready(rdy_o[1]), .rtimer_restart(rst_o[1])
  );

  // Effective waits from R3 / R7: max(value, 2).
  int rp_eff  [2] = '{3, 2};
  int xsr_eff [2] = '{6, 2};

  localparam logic [3:0] C_NOP = 4'b0111, C_INH = 4'b1111,
                         C_PRE = 4'b0010, C_REF = 4'b0001;

  // Reference model: phase 0 idle, 1 precharge, 2 tRP wait, 3 refresh,
  // 4 self-refresh, 5 cke rise, 6 tXSR wait, 7 ready.
  int ph [2];
  int t  [2];
  bit pend [2];

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        ph[i] = 0; t[i] = 0; pend[i] = 1'b0;
      end else begin
        case (ph[i])
          0: if (sleep_req) begin ph[i] = 1; t[i] = 0; end
          1, 2: begin
            if (wake_req) pend[i] = 1'b1;
            t[i] = t[i] + 1;
            ph[i] = (t[i] == rp_eff[i]) ? 3 : 2;
          end
          3: begin
            if (wake_req) pend[i] = 1'b1;
            ph[i] = 4;
          end
          4: if (wake_req || pend[i]) begin ph[i] = 5; t[i] = 0; pend[i] = 1'b0; end
          5, 6: begin
            t[i] = t[i] + 1;
            ph[i] = (t[i] == xsr_eff[i]) ? 7 : 6;
          end
          default: ph[i] = 0;
        endcase
      end
    end
  end

  function automatic string tag_of(int p);
    case (p)
      0: return "R1 R10";
      1: return "R2";
      2: return "R3";
      3: return "R3 R4";
      4: return "R4 R6";
      5: return "R5 R6";
      6: return "R7";
      default: return "R7 R8";
    endcase
  endfunction

  task automatic chk(input int inst, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s inst=%0d time=%0t actual=%b expected=%b", tag, inst, $time, act, exp);
    end
  endtask

  // Compare every output against the model on every cycle, away from the edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      for (int i = 0; i < 2; i++) begin
        logic [3:0] e_cmd;
        logic e_cke;
        e_cmd = (ph[i] == 1) ? C_PRE : (ph[i] == 3) ? C_REF : (ph[i] == 4) ? C_INH : C_NOP;
        e_cke = !(ph[i] == 3 || ph[i] == 4);
        chk(i, {tag_of(ph[i]), " cmd"}, cmd_o[i], e_cmd);
        chk(i, {tag_of(ph[i]), " cke"}, {3'b0, cke_o[i]}, {3'b0, e_cke});
        chk(i, {tag_of(ph[i]), " a10/ba"}, {1'b0, a10_o[i], ba_o[i]}, {1'b0, ph[i] == 1, 2'b00});
        chk(i, "R9 dq_oe", {3'b0, oe_o[i]}, 4'b0);
        chk(i, {tag_of(ph[i]), " ready"}, {3'b0, rdy_o[i]}, {3'b0, ph[i] == 7});
        chk(i, "R8 restart", {3'b0, rst_o[i]}, {3'b0, ph[i] == 7});
      end
    end
  end

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_cycles(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values seen directly.
    chk(0, "R1 reset cmd", cmd_o[0], C_NOP);
    chk(0, "R1 reset cke/ready", {1'b0, cke_o[0], rdy_o[0], rst_o[0]}, 4'b0100);

    // R10: wake while idle does nothing.
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    idle_cycles(3);

    // Isolated entry, long stay, then wake.
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    idle_cycles(40);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    // R5: cke back high with NOP one cycle after the wake.
    chk(0, "R5 cke after wake", {cke_o[0], cmd_o[0][2:0]}, 4'b1111);
    idle_cycles(15);

    // R6: wake pulse during the precharge cycle.
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    idle_cycles(20);

    // R10: sleep held high through whole sequences.
    sleep_req = 1'b1;
    idle_cycles(10);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    idle_cycles(12);
    sleep_req = 1'b0;
    idle_cycles(6);
    wake_req = 1'b1; @(negedge clk); wake_req = 1'b0;
    idle_cycles(15);

    // Wake held high from idle across an entry.
    wake_req = 1'b1;
    sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
    idle_cycles(20);
    wake_req = 1'b0;
    idle_cycles(10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule